// File: doc/BRIEF.md
# Clock Mode and Divider Controller

This block manages the clocks a chip derives from a low-frequency reference multiplied up to a master clock. It keeps a small control word holding a fast/slow speed choice for the multiplier and a three-bit divide code for the processor clock. It produces a processor clock enable at the master rate divided by a power of two. It switches the multiplier on or off from the chip's power mode and display boost setting. It models the multiplier's settling time with a lock counter that raises a ready flag.

Speed changes are deferred. A write to the speed bit is held as a pending request and is applied only once the lock flag is high. Whenever the multiplier is off, the applied speed falls back to slow and any held request is dropped, so every wake-up starts in slow mode. A half-rate debug clock enable runs while a debug pin is high.

Top module: `clkctl_top`

## Requirements
- R1: `pll_en` is 0 when `pwr_mode` is 2'b01 (sleep), or when it is 2'b10 (display-only) with `boost_en` low. It is 1 in every other case, including 2'b00 (active) and 2'b11 (treated as active).
- R2: `ctl_rdata` reads back {3'b000, applied speed, 1'b0, divide code[2:0]}. `stat_rdata` reads back {3'b000, lock, 4'b0000}. After reset the divide code is 3, the speed is slow (0) and lock is 0.
- R3: A write (`wr_en` high, speed in `wr_data[4]`, divide code in `wr_data[2:0]`) whose divide code is 5, 6 or 7 stores 4.
- R4: While `pll_en` is high, `cpu_ce` is a one-cycle pulse every 2^(code+2) clocks. While `pll_en` is low, `cpu_ce` stays 0.
- R5: Lock (`pll_lock`, `stat_rdata[4]`) goes to 0 on the clock edge where the multiplier is off or the applied speed changes. It returns to 1 after LOCK_CYC `ref_tick` pulses counted while the multiplier is on.
- R6: A speed write is held and applied on the first clock edge after the write at which lock is 1. Until then `pll_fast` and `ctl_rdata[4]` keep the old speed.
- R7: While `pll_en` is low, the applied speed is forced to slow and speed writes are discarded. After wake-up the speed stays slow until it is written again.
- R8: While `dbg_pin` and `pll_en` are both high, `dbg_ce` is high on every other clock. Otherwise `dbg_ce` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| pwr_mode | input | 2 | Power mode: 00 active, 01 sleep, 10 display-only, 11 active |
| boost_en | input | 1 | Display boost enable |
| dbg_pin | input | 1 | Debug pin; requests the half-rate debug enable |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Write data: bit 4 speed, bits 2:0 divide code |
| ctl_rdata | output | 8 | Control word readback |
| stat_rdata | output | 8 | Status readback, bit 4 lock |
| pll_en | output | 1 | Multiplier enable |
| pll_fast | output | 1 | Applied multiplier speed (1 fast) |
| pll_lock | output | 1 | Lock ready flag |
| cpu_ce | output | 1 | Processor clock enable |
| dbg_ce | output | 1 | Half-rate debug clock enable |

## Verification
The bench writes a speed change while lock is low and checks that the speed holds until relock. A design that applied it at once would show the new speed early. It also checks that lock drops on the same edge as the speed change; a design that missed this would report ready at the wrong frequency. A speed write is made during sleep and the bench confirms the wake-up still comes up slow. A design that kept the request, or that did not force slow while off, would wake in fast mode. Codes 5 to 7 are written and the pulse period is measured at 64 clocks. An unclamped divider would give a longer period or no pulse at all. The debug enable and the processor enable are also checked to stay silent while the multiplier is off.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'b00,
    PM_SLEEP   = 2'b01,
    PM_DISPLAY = 2'b10,
    PM_ALT     = 2'b11
  } pwr_mode_e;

  // Multiplier needed in this power mode
  function automatic logic pll_needed(input logic [1:0] mode, input logic boost);
    case (mode)
      PM_SLEEP:   pll_needed = 1'b0;
      PM_DISPLAY: pll_needed = boost;
      default:    pll_needed = 1'b1;
    endcase
  endfunction

  // Limit a requested divide code to the largest legal one
  function automatic int clamp_div(input int code, input int max_code);
    clamp_div = (code > max_code) ? max_code : code;
  endfunction

  // Processor enable period in master cycles for a divide code
  function automatic int div_period(input int code);
    div_period = 1 << (code + 2);
  endfunction

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
  parameter int DIV_W     = 3,
  parameter int MAX_DIV   = 4,
  parameter int RESET_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_spd,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             pll_en,
  input  logic             lock,
  output logic             fast,
  output logic [DIV_W-1:0] div,
  output logic             spd_chg
);
  logic fast_q, pend_v, pend_s, apply;
  logic [DIV_W-1:0] div_q;

  // Pending speed applies once lock is seen; a new write takes priority
  always_comb begin
    apply   = pll_en && lock && pend_v && !wr_en;
    spd_chg = apply && (pend_s != fast_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      pend_v <= 1'b0;
      pend_s <= 1'b0;
      div_q  <= DIV_W'(RESET_DIV);
    end else begin
      if (wr_en)
        div_q <= DIV_W'(clkctl_pkg::clamp_div(int'(wr_div), MAX_DIV));
      if (!pll_en) begin
        fast_q <= 1'b0;
        pend_v <= 1'b0;
      end else if (wr_en) begin
        pend_v <= 1'b1;
        pend_s <= wr_spd;
      end else if (apply) begin
        fast_q <= pend_s;
        pend_v <= 1'b0;
      end
    end
  end

  assign fast = fast_q;
  assign div  = div_q;
endmodule

// File: rtl/clkctl_lock.sv
module clkctl_lock #(
  parameter int LOCK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_en,
  input  logic restart,
  input  logic ref_tick,
  output logic lock
);
  localparam int LK_W = $clog2(LOCK_CYC + 1);
  logic [LK_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !pll_en || restart)
      cnt <= '0;
    else if (ref_tick && cnt != LK_W'(LOCK_CYC))
      cnt <= cnt + 1'b1;
  end

  assign lock = (cnt == LK_W'(LOCK_CYC));
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div #(
  parameter int DIV_W   = 3,
  parameter int MAX_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_en,
  input  logic             dbg_pin,
  input  logic [DIV_W-1:0] div,
  output logic             cpu_ce,
  output logic             dbg_ce
);
  localparam int CNT_W = MAX_DIV + 2;
  logic [CNT_W-1:0] cnt, mask;

  always_comb mask = CNT_W'(clkctl_pkg::div_period(int'(div)) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (pll_en)
      cnt <= cnt + 1'b1;
  end

  assign cpu_ce = pll_en && ((cnt & mask) == mask);
  assign dbg_ce = pll_en && dbg_pin && cnt[0];
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top #(
  parameter int DIV_W     = 3,
  parameter int MAX_DIV   = 4,
  parameter int RESET_DIV = 3,
  parameter int LOCK_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [1:0] pwr_mode,
  input  logic       boost_en,
  input  logic       dbg_pin,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctl_rdata,
  output logic [7:0] stat_rdata,
  output logic       pll_en,
  output logic       pll_fast,
  output logic       pll_lock,
  output logic       cpu_ce,
  output logic       dbg_ce
);
  logic [DIV_W-1:0] div;
  logic             spd_chg;

  assign pll_en = clkctl_pkg::pll_needed(pwr_mode, boost_en);

  clkctl_regs #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV), .RESET_DIV(RESET_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_spd(wr_data[4]),
    .wr_div(wr_data[DIV_W-1:0]), .pll_en(pll_en), .lock(pll_lock),
    .fast(pll_fast), .div(div), .spd_chg(spd_chg)
  );

  clkctl_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .restart(spd_chg),
    .ref_tick(ref_tick), .lock(pll_lock)
  );

  clkctl_div #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .dbg_pin(dbg_pin),
    .div(div), .cpu_ce(cpu_ce), .dbg_ce(dbg_ce)
  );

  assign ctl_rdata  = {3'b000, pll_fast, 1'b0, div};
  assign stat_rdata = {3'b000, pll_lock, 4'b0000};
endmodule

// File: rtl/clkctl_checker.sv
module clkctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_en,
  input logic       pll_fast,
  input logic       pll_lock,
  input logic       cpu_ce,
  input logic       dbg_ce,
  input logic [7:0] ctl_rdata
);
  assert_lock_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |=> !pll_lock);

  assert_lock_drop_on_speed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_fast) |-> !pll_lock);

  assert_speed_waits_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_fast) |-> ($past(pll_lock) || !$past(pll_en)));

  assert_slow_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |=> !pll_fast);

  assert_cpu_ce_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> pll_en);

  assert_dbg_half_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ce |=> !dbg_ce);

  assert_div_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[2:0] <= 3'd4);
endmodule

bind clkctl_top clkctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .pll_fast(pll_fast),
  .pll_lock(pll_lock), .cpu_ce(cpu_ce), .dbg_ce(dbg_ce), .ctl_rdata(ctl_rdata)
);

// File: tb/clkctl_top_bench.sv
module clkctl_top_bench;
  localparam int LOCK = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [1:0] pwr_mode = 2'b00;
  logic       boost_en = 1'b0;
  logic       dbg_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctl_rdata, stat_rdata;
  logic       pll_en, pll_fast, pll_lock, cpu_ce, dbg_ce;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit arm = 1'b0;
  int sb[$];

  always #10 clk = ~clk;

  clkctl_top #(.LOCK_CYC(LOCK)) u_clkctl_top (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pwr_mode(pwr_mode),
    .boost_en(boost_en), .dbg_pin(dbg_pin), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata), .pll_en(pll_en),
    .pll_fast(pll_fast), .pll_lock(pll_lock), .cpu_ce(cpu_ce), .dbg_ce(dbg_ce)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ref_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  // Scoreboard driver: program a code, push the expected pulse period
  task automatic run_div(input int code, input int exp_period);
    wr({3'b000, ctl_rdata[4], 1'b0, 3'(code)});
    repeat (70) @(negedge clk);
    sb.push_back(exp_period);
    arm = 1'b1;
    while (sb.size() != 0) @(negedge clk);
    arm = 1'b0;
  endtask

  // Scoreboard monitor: measure spacing of cpu_ce pulses
  int  since = 0;
  bit  have_prev = 1'b0;
  always @(negedge clk) begin
    if (arm) begin
      if (cpu_ce) begin
        if (have_prev && sb.size() > 0) begin
          int e;
          e = sb.pop_front();
          check(since == e, "R4 cpu_ce period", since, e);
        end
        have_prev = 1'b1;
        since = 1;
      end else begin
        since++;
      end
    end else begin
      have_prev = 1'b0;
      since = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state, R1 active mode
    check(ctl_rdata == 8'h03, "R2 reset ctl", ctl_rdata, 8'h03);
    check(stat_rdata == 8'h00, "R2 reset stat", stat_rdata, 0);
    check(pll_en == 1'b1, "R1 active enable", pll_en, 1);

    // R5 lock after LOCK ref ticks
    ref_pulses(LOCK - 1);
    check(pll_lock == 1'b0, "R5 lock early", pll_lock, 0);
    ref_pulses(1);
    check(stat_rdata == 8'h10, "R5 lock rises", stat_rdata, 8'h10);

    // R4 periods for every legal code
    for (int d = 0; d <= 4; d++) run_div(d, 1 << (d + 2));
    // R3 clamp
    wr(8'h07);
    check(ctl_rdata[2:0] == 3'd4, "R3 clamp 7", ctl_rdata[2:0], 4);
    wr(8'h05);
    check(ctl_rdata[2:0] == 3'd4, "R3 clamp 5", ctl_rdata[2:0], 4);
    run_div(6, 64);
    wr(8'h01);

    // R6 speed change with lock high: applied one edge after the write
    wr(8'h11);
    check(pll_fast == 1'b0, "R6 not yet applied", pll_fast, 0);
    @(negedge clk);
    check(ctl_rdata[4] == 1'b1, "R6 applied fast", ctl_rdata[4], 1);
    check(pll_lock == 1'b0, "R5 lock drops on change", pll_lock, 0);

    // R6 held while unlocked
    wr(8'h01);
    repeat (5) @(negedge clk);
    check(pll_fast == 1'b1, "R6 held while unlocked", pll_fast, 1);
    ref_pulses(LOCK);
    @(negedge clk);
    check(pll_fast == 1'b0, "R6 applied after lock", pll_fast, 0);
    ref_pulses(LOCK);
    wr(8'h11);
    @(negedge clk);
    ref_pulses(LOCK);
    check(pll_fast == 1'b1 && pll_lock == 1'b1, "R6 fast and locked", {pll_fast, pll_lock}, 3);

    // R1/R7 sleep: off, forced slow, write discarded, no cpu_ce
    @(negedge clk); pwr_mode = 2'b01;
    #1 check(pll_en == 1'b0, "R1 sleep disables", pll_en, 0);
    @(negedge clk);
    check(pll_fast == 1'b0 && pll_lock == 1'b0, "R7 slow and unlocked", {pll_fast, pll_lock}, 0);
    wr(8'h11);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cpu_ce) n++;
    end
    check(n == 0, "R4 no cpu_ce when off", n, 0);
    pwr_mode = 2'b00;
    ref_pulses(LOCK);
    repeat (3) @(negedge clk);
    check(ctl_rdata[4] == 1'b0, "R7 wake stays slow", ctl_rdata[4], 0);

    // R1 display-only and reserved modes
    pwr_mode = 2'b10; boost_en = 1'b1;
    #1 check(pll_en == 1'b1, "R1 display boost on", pll_en, 1);
    boost_en = 1'b0;
    #1 check(pll_en == 1'b0, "R1 display boost off", pll_en, 0);
    pwr_mode = 2'b11;
    #1 check(pll_en == 1'b1, "R1 mode 11 active", pll_en, 1);
    pwr_mode = 2'b00;

    // R8 debug half-rate enable
    @(negedge clk); dbg_pin = 1'b1;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dbg_ce) n++;
    end
    check(n == 4, "R8 half rate count", n, 4);
    dbg_pin = 1'b0;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dbg_ce) n++;
    end
    check(n == 0, "R8 off when pin low", n, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule